// File: doc/BRIEF.md
# I2C Block Transfer Sequencer

This block runs multi-byte reads and writes against I2C register files and serial EEPROMs. It does not drive the bus lines itself. It sends one command at a time to a byte-level I2C engine. Each command is a byte write, which may be preceded by START, a byte read, which ends with ACK or with NACK and STOP, or a bare STOP. The engine reports back an ACK or NACK for each command, together with any byte it read. A transfer is started with a 7-bit device address, an 8-bit register offset, a byte count, a direction and a legacy-addressing flag. Write data is pulled from a valid/ready byte stream and read data is pushed out as single-cycle valid beats.

A read selects the register with a write-direction address and the offset byte. After a bus-free gap it issues a repeated START in the read direction and clocks out the bytes. A write is cut into small chunks. Each chunk is re-addressed and closed with STOP. The block then probes the device with read-direction addresses until the device acknowledges, which shows that its internal programming cycle has finished. Legacy parts have no device-address byte and take the offset inside the first byte.

Top module: `i2c_blk_xfer`

## Requirements
- R1: A start with a length of zero gives done_o one cycle later with err_o low, and no engine command is issued.
- R2: A normal read issues three commands in this order. First, a write with START of {dev_i, 0}, with the device address in bits 7:1 and the direction bit in bit 0 (1 means read). Second, a write of the offset byte without START. Third, no sooner than GAP_CYC cycles after the offset byte completes, a write with START of {dev_i, 1}.
- R3: In a read, each data byte is fetched with an engine read command. eng_stop_o is low on every read command except the last, where it is high (NACK plus STOP). Each byte appears on rdata_o with a one-cycle rvalid_o pulse, in the order the bytes were received.
- R4: In legacy mode no device-address byte is sent. The first command is a write with START of {offset_i[6:0], rw}, where rw is 1 for a read and 0 for a write. A legacy read then goes directly to the data reads.
- R5: A write sends at most CHUNK data bytes after the addressing bytes and then a STOP command. Engine opcodes are 0 for a byte write, 1 for a byte read and 2 for a STOP. The next chunk is addressed again with the offset advanced by CHUNK.
- R6: After each chunk's STOP, the block sends a write with START of {dev_i, 1}. Each NACK is answered with a STOP and another attempt. After POLL_MAX NACKed attempts the transfer ends with err_o high.
- R7: When an attempt is acknowledged, one byte is read as the final byte, with eng_stop_o high. That byte is discarded and gives no rvalid_o pulse. The next chunk or completion follows.
- R8: A NACK on the device-address byte, the offset byte or any write data byte is followed by a STOP, and then by done_o with err_o high.
- R9: done_o is a one-cycle pulse and err_o is valid with it. A start_i pulse while a transfer is running is ignored.
- R10: eng_req_o stays high with its command fields stable until eng_done_i. wready_o is only raised while no engine command is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| legacy_i | input | 1 | Offset folded into the first byte, no device byte |
| dev_i | input | 7 | Device address |
| offset_i | input | 8 | Register or memory offset |
| len_i | input | LEN_W | Byte count |
| done_o | output | 1 | Transfer finished (one cycle) |
| err_o | output | 1 | Transfer failed, valid with done_o |
| wdata_i | input | 8 | Write data byte |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data accepted this cycle |
| rdata_o | output | 8 | Read data byte |
| rvalid_o | output | 1 | Read data valid (one cycle) |
| eng_req_o | output | 1 | Engine command pending |
| eng_op_o | output | 2 | Engine opcode: 0 write, 1 read, 2 STOP |
| eng_start_o | output | 1 | Precede the byte write with START |
| eng_stop_o | output | 1 | On a read: NACK then STOP, otherwise ACK |
| eng_byte_o | output | 8 | Byte to write |
| eng_done_i | input | 1 | Engine command completed |
| eng_nack_i | input | 1 | Written byte was not acknowledged |
| eng_rdata_i | input | 8 | Byte read by the engine |

## Verification
The embedded assertions cover four properties on every cycle. The engine command must stay stable until completion. The completion flag must be a single pulse. The chunk and poll counters must stay within their bounds. The bus must stay quiet during the repeated-START gap and no data may be fetched while a command is outstanding. Three things depend on a whole transfer and are only shown by the bench's scenarios: the order of the command stream in each mode, the offset advance between chunks, and the correct reaction to NACKs at each position. These scenarios are NACK polling with retries, a poll timeout, and aborts on the address, offset and data bytes.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR_W,
    S_OFFS,
    S_GAP,
    S_ADDR_R,
    S_RDATA,
    S_WFETCH,
    S_WDATA,
    S_CHUNK_STOP,
    S_POLL,
    S_POLL_STOP,
    S_DISCARD,
    S_ABORT
  } seq_state_e;

endpackage

// File: rtl/blk_eng_port.sv
module blk_eng_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [1:0] op_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] byte_i,
  input  logic       done_i,
  output logic       req_o,
  output logic [1:0] op_o,
  output logic       start_o,
  output logic       stop_o,
  output logic [7:0] byte_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      op_o    <= 2'd0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      byte_o  <= 8'h00;
    end else if (issue_i && !req_o) begin
      req_o   <= 1'b1;
      op_o    <= op_i;
      start_o <= start_i;
      stop_o  <= stop_i;
      byte_o  <= byte_i;
    end else if (done_i) begin
      req_o   <= 1'b0;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> (req_o && $stable(op_o) && $stable(byte_o)
                            && $stable(start_o) && $stable(stop_o)));

endmodule

// File: rtl/blk_gap_timer.sv
module blk_gap_timer #(
  parameter int GAP_CYC = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);

  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(GAP_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2
  gap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expired_o);

endmodule

// File: rtl/blk_poll_ctr.sv
module blk_poll_ctr #(
  parameter int POLL_MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic at_max_o
);

  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i)                     cnt_q <= '0;
    else if (inc_i && !at_max_o)          cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == CW'(POLL_MAX));

  // R6
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(POLL_MAX));

endmodule

// File: rtl/i2c_blk_xfer.sv
module i2c_blk_xfer
  import i2c_blk_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int CHUNK    = 4,
  parameter int POLL_MAX = 100,
  parameter int GAP_CYC  = 15000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             legacy_i,
  input  logic [6:0]       dev_i,
  input  logic [7:0]       offset_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o,
  output logic             err_o,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             eng_req_o,
  output logic [1:0]       eng_op_o,
  output logic             eng_start_o,
  output logic             eng_stop_o,
  output logic [7:0]       eng_byte_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_rdata_i
);

  localparam int CW = $clog2(CHUNK + 1);

  seq_state_e       state_q;
  logic [6:0]       dev_q;
  logic [7:0]       offs_q;
  logic [LEN_W-1:0] rem_q;
  logic [CW-1:0]    chunk_q;
  logic [CW-1:0]    clen_q;
  logic             wr_q;
  logic             legacy_q;
  logic [7:0]       wbyte_q;
  logic             done_q;
  logic             err_q;
  logic             rvalid_q;
  logic [7:0]       rdata_q;

  logic             done_ev;
  logic             op_state;
  logic             issue;
  eng_op_e          op_sel;
  logic             start_sel;
  logic             stop_sel;
  logic [7:0]       byte_sel;
  logic             gap_load;
  logic             gap_expired;
  logic             poll_clr;
  logic             poll_inc;
  logic             poll_at_max;

  function automatic logic [CW-1:0] chunk_of(input logic [LEN_W-1:0] n);
    return (n > LEN_W'(CHUNK)) ? CW'(CHUNK) : CW'(n);
  endfunction

  assign done_ev = eng_done_i && eng_req_o;

  // command selection per state
  always_comb begin
    op_state  = 1'b1;
    op_sel    = OP_WR;
    start_sel = 1'b0;
    stop_sel  = 1'b0;
    byte_sel  = 8'h00;
    unique case (state_q)
      S_ADDR_W: begin
        start_sel = 1'b1;
        byte_sel  = legacy_q ? {offs_q[6:0], !wr_q} : {dev_q, 1'b0};
      end
      S_OFFS:   byte_sel = offs_q;
      S_ADDR_R, S_POLL: begin
        start_sel = 1'b1;
        byte_sel  = {dev_q, 1'b1};
      end
      S_RDATA: begin
        op_sel   = OP_RD;
        stop_sel = (rem_q == LEN_W'(1));
      end
      S_DISCARD: begin
        op_sel   = OP_RD;
        stop_sel = 1'b1;
      end
      S_WDATA:  byte_sel = wbyte_q;
      S_CHUNK_STOP, S_POLL_STOP, S_ABORT: op_sel = OP_STOP;
      default:  op_state = 1'b0;
    endcase
  end

  assign issue    = op_state && !eng_req_o;
  assign wready_o = (state_q == S_WFETCH);
  assign gap_load = done_ev && (state_q == S_OFFS) && !eng_nack_i && !wr_q;
  assign poll_clr = done_ev && (state_q == S_CHUNK_STOP);
  assign poll_inc = done_ev && (state_q == S_POLL) && eng_nack_i;

  blk_eng_port u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .op_i    (op_sel),
    .start_i (start_sel),
    .stop_i  (stop_sel),
    .byte_i  (byte_sel),
    .done_i  (eng_done_i),
    .req_o   (eng_req_o),
    .op_o    (eng_op_o),
    .start_o (eng_start_o),
    .stop_o  (eng_stop_o),
    .byte_o  (eng_byte_o)
  );

  blk_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .expired_o (gap_expired)
  );

  blk_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (poll_clr),
    .inc_i    (poll_inc),
    .at_max_o (poll_at_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      dev_q    <= '0;
      offs_q   <= '0;
      rem_q    <= '0;
      chunk_q  <= '0;
      clen_q   <= '0;
      wr_q     <= 1'b0;
      legacy_q <= 1'b0;
      wbyte_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          dev_q    <= dev_i;
          offs_q   <= offset_i;
          rem_q    <= len_i;
          wr_q     <= wr_i;
          legacy_q <= legacy_i;
          chunk_q  <= chunk_of(len_i);
          clen_q   <= chunk_of(len_i);
          if (len_i == '0) begin
            done_q <= 1'b1;
            err_q  <= 1'b0;
          end else begin
            state_q <= S_ADDR_W;
          end
        end
        S_ADDR_W: if (done_ev) begin
          if (eng_nack_i)    state_q <= S_ABORT;
          else if (legacy_q) state_q <= wr_q ? S_WFETCH : S_RDATA;
          else               state_q <= S_OFFS;
        end
        S_OFFS: if (done_ev) begin
          if (eng_nack_i) state_q <= S_ABORT;
          else            state_q <= wr_q ? S_WFETCH : S_GAP;
        end
        S_GAP: if (gap_expired) state_q <= S_ADDR_R;
        S_ADDR_R: if (done_ev) state_q <= eng_nack_i ? S_ABORT : S_RDATA;
        S_RDATA: if (done_ev) begin
          rvalid_q <= 1'b1;
          rdata_q  <= eng_rdata_i;
          rem_q    <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b0;
          end
        end
        S_WFETCH: if (wvalid_i) begin
          wbyte_q <= wdata_i;
          state_q <= S_WDATA;
        end
        S_WDATA: if (done_ev) begin
          if (eng_nack_i) begin
            state_q <= S_ABORT;
          end else begin
            rem_q   <= rem_q - 1'b1;
            chunk_q <= chunk_q - 1'b1;
            state_q <= (chunk_q == CW'(1)) ? S_CHUNK_STOP : S_WFETCH;
          end
        end
        S_CHUNK_STOP: if (done_ev) state_q <= S_POLL;
        S_POLL: if (done_ev) state_q <= eng_nack_i ? S_POLL_STOP : S_DISCARD;
        S_POLL_STOP: if (done_ev) begin
          if (poll_at_max) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            state_q <= S_POLL;
          end
        end
        S_DISCARD: if (done_ev) begin
          if (rem_q == '0) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b0;
          end else begin
            offs_q  <= offs_q + 8'(clen_q);
            chunk_q <= chunk_of(rem_q);
            clen_q  <= chunk_of(rem_q);
            state_q <= S_ADDR_W;
          end
        end
        S_ABORT: if (done_ev) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          err_q   <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  fetch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> !eng_req_o);

  // R5
  chunk_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_q <= CW'(CHUNK));

  // R3
  rdata_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(eng_done_i));

  // R2
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_GAP) |-> !eng_req_o);

endmodule

// File: tb/i2c_blk_xfer_tb.sv
module i2c_blk_xfer_tb;

  localparam int LEN_W = 8;
  localparam int GAP   = 20;
  localparam int PMAX  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start_i = 1'b0;
  logic             wr_i = 1'b0;
  logic             legacy_i = 1'b0;
  logic [6:0]       dev_i = '0;
  logic [7:0]       offset_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             done_o, err_o;
  logic [7:0]       wdata_i = '0;
  logic             wvalid_i = 1'b0;
  logic             wready_o;
  logic [7:0]       rdata_o;
  logic             rvalid_o;
  logic             eng_req_o;
  logic [1:0]       eng_op_o;
  logic             eng_start_o, eng_stop_o;
  logic [7:0]       eng_byte_o;
  logic             eng_done_i = 1'b0;
  logic             eng_nack_i = 1'b0;
  logic [7:0]       eng_rdata_i = '0;

  i2c_blk_xfer #(.LEN_W(LEN_W), .CHUNK(4), .POLL_MAX(PMAX), .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .wr_i(wr_i),
    .legacy_i(legacy_i), .dev_i(dev_i), .offset_i(offset_i), .len_i(len_i),
    .done_o(done_o), .err_o(err_o), .wdata_i(wdata_i), .wvalid_i(wvalid_i),
    .wready_o(wready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .eng_req_o(eng_req_o), .eng_op_o(eng_op_o), .eng_start_o(eng_start_o),
    .eng_stop_o(eng_stop_o), .eng_byte_o(eng_byte_o), .eng_done_i(eng_done_i),
    .eng_nack_i(eng_nack_i), .eng_rdata_i(eng_rdata_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string cur_req = "R1";

  // scoreboard: {op[1:0], start, stop, byte[7:0]}
  logic [11:0] exp_q[$];
  logic [7:0]  exp_rd[$];
  logic [7:0]  wq[$];
  int  rd_idx = 0;
  int  poll_nacks = 0;
  logic nack_en = 1'b0;
  logic [7:0] nack_val = '0;
  logic chk_gap = 1'b0;
  int  last_done_cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_wr(input bit st, input logic [7:0] b);
    exp_q.push_back({2'd0, st, 1'b0, b});
  endtask
  task automatic exp_rdop(input bit last);
    exp_q.push_back({2'd1, 1'b0, last, 8'h00});
  endtask
  task automatic exp_stop();
    exp_q.push_back({2'd2, 1'b0, 1'b0, 8'h00});
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // engine model, write-data source and monitor
  initial begin
    bit prev_req = 0, resp_busy = 0, nack_pend = 0, hs_pend = 0;
    int resp_cnt = 0;
    logic [7:0] rd_byte = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(0, cur_req, "watchdog expired", cyc, 0);
        finish_run();
      end
      eng_done_i = 1'b0;
      if (hs_pend && wq.size() > 0) void'(wq.pop_front());
      wvalid_i = (wq.size() > 0);
      wdata_i  = wvalid_i ? wq[0] : 8'h00;
      hs_pend  = wvalid_i && wready_o;
      if (resp_busy) begin
        if (resp_cnt == 0) begin
          eng_done_i  = 1'b1;
          eng_nack_i  = nack_pend;
          eng_rdata_i = rd_byte;
          resp_busy   = 0;
          last_done_cyc = cyc;
        end else begin
          resp_cnt--;
        end
      end
      if (eng_req_o && !prev_req) begin
        logic [11:0] e;
        if (exp_q.size() == 0) begin
          check(0, cur_req, "unexpected engine op", {eng_op_o, eng_start_o, eng_stop_o, eng_byte_o}, 0);
        end else begin
          e = exp_q.pop_front();
          check(eng_op_o == e[11:10], cur_req, "engine opcode", eng_op_o, e[11:10]);
          if (e[11:10] == 2'd0) begin
            check(eng_start_o == e[9], cur_req, "start flag", eng_start_o, e[9]);
            check(eng_byte_o == e[7:0], cur_req, "written byte", eng_byte_o, e[7:0]);
          end
          if (e[11:10] == 2'd1)
            check(eng_stop_o == e[8], cur_req, "read last flag", eng_stop_o, e[8]);
        end
        if (chk_gap && eng_op_o == 2'd0 && eng_start_o && eng_byte_o[0]) begin
          // R2: repeated START only after the bus-free gap
          check((cyc - last_done_cyc) >= GAP, "R2", "gap cycles", cyc - last_done_cyc, GAP);
          chk_gap = 1'b0;
        end
        nack_pend = 1'b0;
        if (eng_op_o == 2'd0) begin
          if (nack_en && eng_byte_o == nack_val) nack_pend = 1'b1;
          if (eng_start_o && eng_byte_o[0] && poll_nacks > 0) begin
            nack_pend = 1'b1;
            poll_nacks--;
          end
        end
        if (eng_op_o == 2'd1) begin
          rd_byte = 8'hC0 + 8'(rd_idx);
          rd_idx++;
        end
        resp_busy = 1;
        resp_cnt  = 2;
      end
      prev_req = eng_req_o;
      if (rvalid_o) begin
        if (exp_rd.size() == 0) begin
          check(0, "R7", "unexpected read data", rdata_o, 0);
        end else begin
          logic [7:0] x;
          x = exp_rd.pop_front();
          check(rdata_o == x, "R3", "read data", rdata_o, x);
        end
      end
    end
  end

  task automatic launch(input bit wr, input bit leg, input logic [6:0] dev,
                        input logic [7:0] off, input int len);
    @(negedge clk);
    wr_i = wr; legacy_i = leg; dev_i = dev; offset_i = off; len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req, input bit exp_err);
    int t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done_o, req, "done seen", done_o, 1);
    if (done_o) check(err_o == exp_err, req, "error flag", err_o, exp_err);
    @(negedge clk);
    check(exp_q.size() == 0, req, "missing engine ops", exp_q.size(), 0);
    check(exp_rd.size() == 0, req, "missing read beats", exp_rd.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 R10 reset state
    check(!done_o && !rvalid_o && !wready_o && !eng_req_o, "R9", "reset outputs",
          {done_o, rvalid_o, wready_o, eng_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: zero length
    cur_req = "R1";
    launch(1'b0, 1'b0, 7'h50, 8'h10, 0);
    check(done_o && !err_o, "R1", "zero-length done", {done_o, err_o}, 2'b10);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R1", "no op queue", exp_q.size(), 0);

    // R2 R3 R9: normal read of 3, stray start ignored
    cur_req = "R2";
    exp_wr(1, 8'hA0); exp_wr(0, 8'h10); exp_wr(1, 8'hA1);
    exp_rdop(0); exp_rdop(0); exp_rdop(1);
    for (int i = 0; i < 3; i++) exp_rd.push_back(8'hC0 + 8'(rd_idx + i));
    chk_gap = 1'b1;
    launch(1'b0, 1'b0, 7'h50, 8'h10, 3);
    repeat (4) @(negedge clk);
    launch(1'b1, 1'b0, 7'h22, 8'h00, 0);
    wait_done("R9", 1'b0);
    check(chk_gap == 1'b0, "R2", "gap check reached", chk_gap, 0);

    // R4: legacy read of 2
    cur_req = "R4";
    exp_wr(1, 8'h43); exp_rdop(0); exp_rdop(1);
    for (int i = 0; i < 2; i++) exp_rd.push_back(8'hC0 + 8'(rd_idx + i));
    launch(1'b0, 1'b1, 7'h50, 8'h21, 2);
    wait_done("R4", 1'b0);

    // R5 R6 R7: write of 6 in two chunks, two busy polls
    cur_req = "R5";
    poll_nacks = 2;
    exp_wr(1, 8'hA0); exp_wr(0, 8'h08);
    exp_wr(0, 8'h11); exp_wr(0, 8'h22); exp_wr(0, 8'h33); exp_wr(0, 8'h44); exp_stop();
    exp_wr(1, 8'hA1); exp_stop(); exp_wr(1, 8'hA1); exp_stop();
    exp_wr(1, 8'hA1); exp_rdop(1);
    exp_wr(1, 8'hA0); exp_wr(0, 8'h0C);
    exp_wr(0, 8'h55); exp_wr(0, 8'h66); exp_stop();
    exp_wr(1, 8'hA1); exp_rdop(1);
    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    launch(1'b1, 1'b0, 7'h50, 8'h08, 6);
    wait_done("R6", 1'b0);
    check(poll_nacks == 0, "R6", "busy polls consumed", poll_nacks, 0);

    // R4 R7: legacy write of 2
    cur_req = "R4";
    exp_wr(1, 8'h0A); exp_wr(0, 8'h77); exp_wr(0, 8'h88); exp_stop();
    exp_wr(1, 8'hA1); exp_rdop(1);
    wq = '{8'h77, 8'h88};
    launch(1'b1, 1'b1, 7'h50, 8'h05, 2);
    wait_done("R7", 1'b0);

    // R8: NACK on device address
    cur_req = "R8";
    nack_en = 1'b1; nack_val = 8'h66;
    exp_wr(1, 8'h66); exp_stop();
    launch(1'b0, 1'b0, 7'h33, 8'h01, 2);
    wait_done("R8", 1'b1);

    // R8: NACK on offset
    nack_val = 8'h7E;
    exp_wr(1, 8'hA0); exp_wr(0, 8'h7E); exp_stop();
    launch(1'b0, 1'b0, 7'h50, 8'h7E, 2);
    wait_done("R8", 1'b1);

    // R8: NACK on second write data byte
    nack_val = 8'hEE;
    exp_wr(1, 8'hA0); exp_wr(0, 8'h40); exp_wr(0, 8'h12); exp_wr(0, 8'hEE); exp_stop();
    wq = '{8'h12, 8'hEE, 8'h34};
    launch(1'b1, 1'b0, 7'h50, 8'h40, 3);
    wait_done("R8", 1'b1);
    check(wq.size() == 1, "R8", "unfetched data left", wq.size(), 1);
    wq.delete();
    nack_en = 1'b0;

    // R6: poll timeout
    cur_req = "R6";
    poll_nacks = PMAX;
    exp_wr(1, 8'hA0); exp_wr(0, 8'h02); exp_wr(0, 8'h99); exp_stop();
    for (int i = 0; i < PMAX; i++) begin
      exp_wr(1, 8'hA1); exp_stop();
    end
    wq = '{8'h99};
    launch(1'b1, 1'b0, 7'h50, 8'h02, 1);
    wait_done("R6", 1'b1);
    poll_nacks = 0;

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule